// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that a host uses to read and write registers inside Ethernet PHYs. The host sees two 16-bit registers behind one select line: a command word and a data word. A single write of the command word with its start bit set launches a complete management frame. The same word carries the PHY address, the register number, a divider code and the direction. The block generates the management clock, shifts the frame out MSB first, releases the data line for the PHY's reply on reads, and clears the busy bit by itself when the frame ends.

For a write, the host loads the data word first and then issues the command. For a read, the host issues the command, polls until busy reads 0, and then reads the data word. A command written with the start bit clear runs no frame but still produces one management-clock pulse. Some PHYs need this to leave reset.

Top module: `mdio_master`

## Requirements
- R1: The command word reads back as bits 15:11 PHY address, 10:6 register number, 5:2 divider code, 1 direction (1 = write to the PHY, 0 = read), 0 busy. Select 0 addresses the command word and select 1 the data word.
- R2: An accepted command write with bit 0 set makes bit 0 read 1 from the next cycle for exactly 64 MDC periods, after which it reads 0 again.
- R3: Each frame is 64 bits, sent MSB first on MDC rising edges: 32 ones, start 01, opcode 01 for write or 10 for read, 5-bit PHY address, 5-bit register number, turnaround, 16 data bits.
- R4: A write frame drives MDIO for all 64 bits, with turnaround 10 and the data word as payload. The data word is left unchanged.
- R5: A read frame releases MDIO from bit 46 (turnaround) to the end and samples MDIO on each MDC rising edge of bits 48..63. When busy clears, the data word holds those 16 bits, first sampled in bit 15.
- R6: The MDC period in system clocks is MIN_DIV·2^code for codes below NUM_RANGES; any larger code uses the largest of those periods. MDC is high for exactly half of each period.
- R7: A command write with bit 0 clear, while idle, stores the fields, keeps busy at 0, leaves MDIO released and gives exactly one MDC pulse with a high time of half the selected period.
- R8: While MDC is running, writes to either register are ignored. Reads of both registers are allowed at any time.
- R9: After reset both registers read 0, MDC is low and MDIO is released.
- R10: While a frame runs, the driven MDIO value changes only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regSel | input | 1 | Register select: 0 command word, 1 data word (read and write) |
| regWrData | input | 16 | Host write data |
| regRdData | output | 16 | Selected register contents |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable; 0 releases the line |
| mdioIn | input | 1 | MDIO value seen on the line |

## Verification
A wrong divider code or period counter shows up as a busy time that differs from 64 periods. The bench measures that time to the exact cycle for every code class, so the error is visible when the first frame ends. A slip in the bit counter or the shift register moves or corrupts frame bits, and this is caught at the MDC rising edge of the first wrong bit. A bad release point shows as MDIO still enabled during the turnaround. A missing busy guard shows up at the ports once the frame ends, because the command or data word then reads back altered.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TURN_BIT   = 46;
  localparam int DATA_BIT   = 48;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic load;      // latch a new frame into the shifter
    logic shiftBit;  // advance to the next frame bit
    logic sampleIn;  // capture the line into the receive shifter
    logic finish;    // last bit period ends
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int MIN_DIV    = 64,
  parameter int NUM_RANGES = 4,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic              cmdStart,
  input  logic [CODE_W-1:0] divCode,
  input  logic              isWrite,
  output mdioStrobe_t       strobe,
  output logic              busy,
  output logic              engineActive,
  output logic              mdc,
  output logic              mdioOe,
  output logic [BIT_W-1:0]  bitIdx
);
  localparam int CODES      = 1 << CODE_W;
  localparam int MAX_PERIOD = MIN_DIV << (NUM_RANGES - 1);
  localparam int DIV_W      = $clog2(MAX_PERIOD);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_PULSE} ctrlState_t;

  ctrlState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfTab [CODES];
  logic [DIV_W-1:0] half;
  logic [DIV_W:0]   periodFull;
  logic [DIV_W-1:0] lastCnt;
  logic [DIV_W-1:0] riseCnt;
  logic             periodEnd;
  logic             lastBit;

  // half-period per code; codes past the defined range saturate at the slowest
  for (genvar g = 0; g < CODES; g++) begin : g_halfTab
    localparam int SHIFT = (g < NUM_RANGES) ? g : NUM_RANGES - 1;
    assign halfTab[g] = DIV_W'((MIN_DIV / 2) << SHIFT);
  end

  assign half       = halfTab[divCode];
  assign periodFull = {half, 1'b0};
  assign lastCnt    = DIV_W'(periodFull - 1'b1);
  assign riseCnt    = half - 1'b1;
  assign periodEnd  = (divCnt == lastCnt);
  assign lastBit    = (bitIdx == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      mdc    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          mdc <= 1'b0;
          if (cmdWr) begin
            divCnt <= '0;
            bitIdx <= '0;
            state  <= cmdStart ? ST_FRAME : ST_PULSE;
          end
        end
        default: begin
          if (periodEnd) begin
            divCnt <= '0;
            mdc    <= 1'b0;
            if (state == ST_PULSE || lastBit) state <= ST_IDLE;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
            if (divCnt == riseCnt) mdc <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy         = (state == ST_FRAME);
  assign engineActive = (state != ST_IDLE);
  assign mdioOe       = busy && (isWrite || bitIdx < BIT_W'(TURN_BIT));

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && cmdWr && cmdStart;
    strobe.shiftBit = busy && periodEnd && !lastBit;
    strobe.finish   = busy && periodEnd && lastBit;
    strobe.sampleIn = busy && !isWrite && (divCnt == riseCnt) &&
                      (bitIdx >= BIT_W'(DATA_BIT));
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [15:0]       regWrData,
  input  logic              engineActive,
  input  logic              busy,
  input  mdioStrobe_t       strobe,
  input  logic              mdioIn,
  output logic              cmdWr,
  output logic              cmdStart,
  output logic [CODE_W-1:0] divCode,
  output logic              isWrite,
  output logic              txBit,
  output logic [14:0]       cmdFields,
  output logic [15:0]       dataWord,
  output logic [15:0]       regRdData
);
  logic [FRAME_BITS-1:0] frameSr;
  logic [15:0]           rxSr;
  logic                  dataWr;
  logic                  newWrite;

  assign cmdWr    = regWrEn && !regSel && !engineActive;
  assign dataWr   = regWrEn && regSel && !engineActive;
  assign cmdStart = regWrData[0];
  assign newWrite = regWrData[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdFields <= '0;
      dataWord  <= '0;
      frameSr   <= '0;
      rxSr      <= '0;
    end else begin
      if (cmdWr) cmdFields <= regWrData[15:1];
      if (dataWr) dataWord <= regWrData;
      if (strobe.load) begin
        frameSr <= {32'hFFFF_FFFF, 2'b01,
                    newWrite ? 2'b01 : 2'b10,
                    regWrData[15:11], regWrData[10:6],
                    newWrite ? 2'b10 : 2'b00,
                    newWrite ? dataWord : 16'h0000};
      end else if (strobe.shiftBit) begin
        frameSr <= {frameSr[FRAME_BITS-2:0], 1'b0};
      end
      if (strobe.sampleIn) rxSr <= {rxSr[14:0], mdioIn};
      if (strobe.finish && !isWrite) dataWord <= rxSr;
    end
  end

  assign divCode   = cmdFields[CODE_W:1];
  assign isWrite   = cmdFields[0];
  assign txBit     = frameSr[FRAME_BITS-1];
  assign regRdData = regSel ? dataWord : {cmdFields, busy};
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MIN_DIV    = 64,
  parameter int NUM_RANGES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int CODE_W = 4;

  mdioStrobe_t       strobe;
  logic              cmdWr;
  logic              cmdStart;
  logic [CODE_W-1:0] divCode;
  logic              isWrite;
  logic              txBit;
  logic              busyFlag;
  logic              engineActive;
  logic [BIT_W-1:0]  bitIdx;
  logic [14:0]       cmdFields;
  logic [15:0]       dataWord;

  mdio_ctrl #(
    .MIN_DIV(MIN_DIV), .NUM_RANGES(NUM_RANGES), .CODE_W(CODE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdStart(cmdStart),
    .divCode(divCode), .isWrite(isWrite), .strobe(strobe),
    .busy(busyFlag), .engineActive(engineActive), .mdc(mdc),
    .mdioOe(mdioOe), .bitIdx(bitIdx)
  );

  mdio_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .engineActive(engineActive), .busy(busyFlag),
    .strobe(strobe), .mdioIn(mdioIn), .cmdWr(cmdWr), .cmdStart(cmdStart),
    .divCode(divCode), .isWrite(isWrite), .txBit(txBit),
    .cmdFields(cmdFields), .dataWord(dataWord), .regRdData(regRdData)
  );

  assign mdioOut = mdioOe & txBit;
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regSel,
  input logic [15:0] regWrData,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        busyFlag,
  input logic        engineActive,
  input logic        isWrite,
  input logic [5:0]  bitIdx,
  input logic [14:0] cmdFields,
  input logic [15:0] dataWord
);
  a_r2_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> $past(regWrEn && !regSel && regWrData[0]));

  a_r2_busy_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyFlag) |-> !mdc);

  a_r5_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && !isWrite && bitIdx >= 6'd46) |-> !mdioOe);

  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (engineActive && regWrEn && !regSel) |=> $stable(cmdFields));

  a_r8_data_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (engineActive && isWrite && regWrEn && regSel) |=> $stable(dataWord));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !engineActive |-> (!mdc && !mdioOe));

  a_r10_change_low: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && !$stable(mdioOut)) |-> !mdc);
endmodule

bind mdio_master mdio_master_checker u_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .regWrData(regWrData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busyFlag(busyFlag), .engineActive(engineActive), .isWrite(isWrite),
  .bitIdx(bitIdx), .cmdFields(cmdFields), .dataWord(dataWord)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int MIN_DIV = 64;
  localparam int NUM_VEC = 6;

  // {write, phy[4:0], reg[4:0], code[3:0], data[15:0]}
  localparam logic [30:0] VECS [NUM_VEC] = '{
    {1'b1, 5'd1,  5'd2,  4'd0,  16'hA5C3},
    {1'b0, 5'd5,  5'd17, 4'd1,  16'h3C5A},
    {1'b1, 5'd16, 5'd1,  4'd2,  16'h0001},
    {1'b0, 5'd10, 5'd21, 4'd15, 16'h8001},
    {1'b0, 5'd0,  5'd0,  4'd0,  16'hFFFF},
    {1'b1, 5'd31, 5'd31, 4'd0,  16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  int   capIdx = 0;
  logic capOut [64];
  logic capOe  [64];
  logic [15:0] phyVal = '0;

  always #2 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: answers data bits 48..63 MSB first, otherwise idles high
  assign mdioIn = (capIdx >= 48 && capIdx < 64) ? phyVal[63 - capIdx] : 1'b1;

  always @(posedge mdc) begin
    if (capIdx < 64) begin
      capOut[capIdx] = mdioOut;
      capOe[capIdx]  = mdioOe;
    end
    capIdx = capIdx + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 1'b0;
  endtask

  function automatic int periodOf(input logic [3:0] code);
    return MIN_DIV << ((code < 4) ? code : 3);
  endfunction

  function automatic logic [63:0] expFrame(input logic wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
            wr ? 2'b10 : 2'b00, wr ? d : 16'h0000};
  endfunction

  task automatic waitBusy(output int cycles);
    cycles = 0;
    regSel = 1'b0;
    #0;
    while (regRdData[0]) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic checkFrame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] d);
    logic [63:0] ef;
    int hdrBad, payBad, relBad;
    ef = expFrame(wr, phy, rg, d);
    hdrBad = 0; payBad = 0; relBad = 0;
    check("R3 mdc rising edges", capIdx, 64);
    for (int i = 0; i < 64; i++) begin
      if (i < 46) begin
        if (capOe[i] !== 1'b1 || capOut[i] !== ef[63 - i]) hdrBad++;
      end else if (wr) begin
        if (capOe[i] !== 1'b1 || capOut[i] !== ef[63 - i]) begin
          if (i < 48) hdrBad++; else payBad++;
        end
      end else if (capOe[i] !== 1'b0) relBad++;
    end
    check("R3 header bit errors", hdrBad, 0);
    if (wr) check("R4 payload bit errors", payBad, 0);
    else    check("R5 released bits driven", relBad, 0);
  endtask

  task automatic runVector(input logic [30:0] v);
    logic wr; logic [4:0] phy, rg; logic [3:0] code; logic [15:0] d;
    logic [15:0] cmd;
    int cyc;
    {wr, phy, rg, code, d} = v;
    cmd = {phy, rg, code, wr, 1'b1};
    if (wr) regWrite(1'b1, d);
    phyVal = d;
    capIdx = 0;
    regWrite(1'b0, cmd);
    check("R2 busy set after start", regRdData[0], 1'b1);
    waitBusy(cyc);
    check("R2/R6 busy cycles", cyc, 64 * periodOf(code));
    check("R1 command readback", regRdData, {cmd[15:1], 1'b0});
    checkFrame(wr, phy, rg, d);
    regSel = 1'b1; #0;
    if (wr) check("R4 data word kept", regRdData, d);
    else    check("R5 read data", regRdData, d);
    regSel = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc, hiCnt, oeCnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 command after reset", regRdData, 16'h0000);
    regSel = 1'b1; #0;
    check("R9 data after reset", regRdData, 16'h0000);
    regSel = 1'b0;
    check("R9 mdc low", mdc, 1'b0);
    check("R9 mdio released", mdioOe, 1'b0);

    for (int k = 0; k < NUM_VEC; k++) runVector(VECS[k]);

    // R7 all-zero command: one MDC pulse, nothing driven, busy stays low
    capIdx = 0;
    regWrite(1'b0, 16'h0000);
    check("R7 busy stays clear", regRdData[0], 1'b0);
    hiCnt = 0; oeCnt = 0;
    for (int i = 0; i < 200; i++) begin
      if (mdc) hiCnt++;
      if (mdioOe) oeCnt++;
      @(negedge clk);
    end
    check("R7 single pulse", capIdx, 1);
    check("R6/R7 pulse high time", hiCnt, MIN_DIV / 2);
    check("R7 mdio released", oeCnt, 0);

    // R7 fields stored by a non-start write with code 1
    regWrite(1'b0, {5'd7, 5'd9, 4'd1, 1'b1, 1'b0});
    check("R7 fields stored", regRdData, {5'd7, 5'd9, 4'd1, 1'b1, 1'b0});
    hiCnt = 0;
    for (int i = 0; i < 200; i++) begin
      if (mdc) hiCnt++;
      @(negedge clk);
    end
    check("R6 code 1 high time", hiCnt, MIN_DIV);

    // R8 writes during a write frame are ignored
    regWrite(1'b1, 16'hBEEF);
    phyVal = 16'h0000;
    capIdx = 0;
    regWrite(1'b0, {5'd3, 5'd4, 4'd0, 1'b1, 1'b1});
    repeat (200) @(negedge clk);
    regWrite(1'b0, {5'd12, 5'd13, 4'd2, 1'b0, 1'b1});
    regWrite(1'b1, 16'h1234);
    check("R8 busy readable mid frame", regRdData[0], 1'b1);
    waitBusy(cyc);
    check("R8 command unchanged", regRdData, {5'd3, 5'd4, 4'd0, 1'b1, 1'b0});
    checkFrame(1'b1, 5'd3, 5'd4, 16'hBEEF);
    regSel = 1'b1; #0;
    check("R8 data unchanged", regRdData, 16'hBEEF);
    regSel = 1'b0;
    @(negedge clk);
    check("R9 idle after frames mdc", mdc, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule